// File: doc/BRIEF.md
# Gated Event Counter

This block measures how many rising edges arrive on an asynchronous event input during a repeating measurement window. Software writes a four-bit window code. After a fixed start delay the block opens an internal gate for a window of that code times a base period. It then closes the gate for one base period and opens it again, and this repeats with the same window length until the code is written again. A copy of the gate, delayed by a fixed two cycles, is driven out to external logic.

At each window opening the live counter and both status flags are cleared. At each window close the count is copied into a holding register, which stays stable for software to read until the next close. A completion flag and an overflow flag, each with its own enable, drive a shared interrupt line. When wait mode is active, that interrupt also raises a wake request. Stop mode freezes the whole measurement.

Top module: `gated_event_counter`

## Requirements
- R1: After the clock edge that samples a write with a nonzero code, the internal gate goes high at the fourth following rising edge.
- R2: The gate stays high for exactly code × BASE_CYCLES cycles and then low for BASE_CYCLES cycles. This repeats with the same lengths.
- R3: The external gate output equals the internal gate delayed by exactly two clock cycles.
- R4: Each rising edge of the synchronised event input that is seen while the gate is open adds one to a CNT_W-bit counter (16 bits by default). The counter is zeroed at the opening edge. The holding register takes the final count at the closing edge and keeps it until the next close.
- R5: The completion flag is set at the edge that closes the window. The interrupt is high while the completion flag and the completion enable are both set.
- R6: An increment from all ones wraps the counter to zero, sets the overflow flag and counting goes on. The interrupt is high while the overflow flag and the overflow enable are both set.
- R7: A pulse on the completion-clear input clears only the completion flag. A pulse on the overflow-clear input clears only the overflow flag. A set in the same cycle wins over a clear.
- R8: Both flags read zero from the edge that opens each window.
- R9: In wait mode counting continues. The wake request is high whenever the interrupt is high and wait mode is asserted.
- R10: While stop mode is asserted, no events are counted and the gate sequence holds its position.
- R11: Writing a code of zero leaves the gate low from the next cycle and stops gate generation.
- R12: After reset the gates, flags, interrupt, wake request and holding register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tc_wr | input | 1 | Write strobe for the window code |
| tc_data | input | 4 | Window code (0 disables the gate) |
| en_done | input | 1 | Completion interrupt enable |
| en_ovf | input | 1 | Overflow interrupt enable |
| clr_done | input | 1 | Write-one pulse that clears the completion flag |
| clr_ovf | input | 1 | Write-one pulse that clears the overflow flag |
| event_in | input | 1 | Asynchronous event input |
| wait_mode | input | 1 | Wait low-power state |
| stop_mode | input | 1 | Stop low-power state |
| gate_int | output | 1 | Internal measurement gate (high while open) |
| gate_ext | output | 1 | External gate, two cycles behind |
| count_hold | output | CNT_W | Count of the last completed window |
| flag_done | output | 1 | Completion flag |
| flag_ovf | output | 1 | Overflow flag |
| irq | output | 1 | Combined enabled interrupt |
| wake_req | output | 1 | Wake request during wait mode |

## Verification
The hardest case to reach is a counter wrap inside a single window. With default widths this would take 65536 event edges. The bench therefore builds the block with an 8-bit counter and a longer base period. It then toggles the event input every cycle for 257 edges inside one maximum-length window, so the wrap, the overflow interrupt and the final count of one can all be observed. Stop mode is applied while a window is open, with an event pulse placed entirely inside the stop interval, to show that this pulse is lost and that events before and after it are still counted.

// File: rtl/gec_pkg.sv
package gec_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARM,
        SEQ_OPEN,
        SEQ_GAP
    } seq_st_t;

    typedef struct packed {
        logic open_now;
        logic start;
        logic close;
    } gate_ev_t;

    localparam int unsigned START_DELAY = 4;

    function automatic int unsigned win_cycles(input logic [3:0] code, input int unsigned base);
        return int'(code) * base;
    endfunction

endpackage

// File: rtl/gec_sync_edge.sv
module gec_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/gec_gate_seq.sv
module gec_gate_seq
    import gec_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tc_wr,
    input  logic [3:0] tc_data,
    output gate_ev_t   ev
);
    localparam int unsigned MAX_WIN = 15 * BASE_CYCLES;
    localparam int          TMR_W   = $clog2(MAX_WIN + 1);

    seq_st_t          st;
    logic [TMR_W-1:0] tmr;
    logic [3:0]       code;
    logic             tmr_zero;
    logic             step;

    assign tmr_zero = (tmr == '0);
    assign step     = run & ~tc_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SEQ_IDLE;
            tmr  <= '0;
            code <= '0;
        end else if (tc_wr) begin
            code <= tc_data;
            if (tc_data == 4'd0) begin
                st  <= SEQ_IDLE;
                tmr <= '0;
            end else begin
                st  <= SEQ_ARM;
                tmr <= TMR_W'(START_DELAY - 1);
            end
        end else if (run) begin
            unique case (st)
                SEQ_ARM, SEQ_GAP: begin
                    if (tmr_zero) begin
                        st  <= SEQ_OPEN;
                        tmr <= TMR_W'(win_cycles(code, BASE_CYCLES) - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SEQ_OPEN: begin
                    if (tmr_zero) begin
                        st  <= SEQ_GAP;
                        tmr <= TMR_W'(BASE_CYCLES - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: tmr <= '0;
            endcase
        end
    end

    always_comb begin
        ev.open_now = (st == SEQ_OPEN);
        ev.start    = step & tmr_zero & ((st == SEQ_ARM) | (st == SEQ_GAP));
        ev.close    = step & tmr_zero & (st == SEQ_OPEN);
    end
endmodule

// File: rtl/gec_event_cnt.sv
module gec_event_cnt
    import gec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  gate_ev_t         ev,
    input  logic             run,
    input  logic             rise,
    input  logic             clr_done,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] hold,
    output logic             done,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             inc;
    logic             wrap;

    assign inc    = rise & run & ev.open_now;
    assign wrap   = inc & (&cnt);
    assign cnt_nx = inc ? cnt + 1'b1 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hold <= '0;
            done <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (ev.start) cnt <= '0;
            else          cnt <= cnt_nx;

            if (ev.close) hold <= cnt_nx;

            if (ev.start)      done <= 1'b0;
            else if (ev.close) done <= 1'b1;
            else if (clr_done) done <= 1'b0;

            if (ev.start)      ovf <= 1'b0;
            else if (wrap)     ovf <= 1'b1;
            else if (clr_ovf)  ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
    import gec_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 8,
    parameter int          CNT_W       = 16,
    parameter int          SYNC_STAGES = 2,
    parameter int          EXT_DLY     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tc_wr,
    input  logic [3:0]       tc_data,
    input  logic             en_done,
    input  logic             en_ovf,
    input  logic             clr_done,
    input  logic             clr_ovf,
    input  logic             event_in,
    input  logic             wait_mode,
    input  logic             stop_mode,
    output logic             gate_int,
    output logic             gate_ext,
    output logic [CNT_W-1:0] count_hold,
    output logic             flag_done,
    output logic             flag_ovf,
    output logic             irq,
    output logic             wake_req
);
    gate_ev_t           ev;
    logic               rise;
    logic               run;
    logic [EXT_DLY-1:0] ext_pipe;

    assign run = ~stop_mode;

    gec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (event_in),
        .rise(rise)
    );

    gec_gate_seq #(.BASE_CYCLES(BASE_CYCLES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tc_wr  (tc_wr),
        .tc_data(tc_data),
        .ev     (ev)
    );

    gec_event_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .run     (run),
        .rise    (rise),
        .clr_done(clr_done),
        .clr_ovf (clr_ovf),
        .hold    (count_hold),
        .done    (flag_done),
        .ovf     (flag_ovf)
    );

    generate
        if (EXT_DLY == 1) begin : g_ext1
            always_ff @(posedge clk) begin
                if (rst) ext_pipe <= '0;
                else     ext_pipe <= ev.open_now;
            end
        end else begin : g_extn
            always_ff @(posedge clk) begin
                if (rst) ext_pipe <= '0;
                else     ext_pipe <= {ext_pipe[EXT_DLY-2:0], ev.open_now};
            end
        end
    endgenerate

    assign gate_int = ev.open_now;
    assign gate_ext = ext_pipe[EXT_DLY-1];
    assign irq      = (flag_done & en_done) | (flag_ovf & en_ovf);
    assign wake_req = irq & wait_mode;
endmodule

// File: rtl/gec_checker.sv
module gec_checker (
    input logic       clk,
    input logic       rst,
    input logic       tc_wr,
    input logic [3:0] tc_data,
    input logic       stop_mode,
    input logic       wait_mode,
    input logic       irq,
    input logic       wake_req,
    input logic       gate_int,
    input logic       gate_ext,
    input logic       flag_done,
    input logic       flag_ovf,
    input logic       count_hold_chg
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r3_ext_lag: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (gate_ext == $past(gate_int, 2)));

    a_r8_flags_clear_at_open: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $rose(gate_int) |-> (!flag_done && !flag_ovf));

    a_r5_done_at_close: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $fell(gate_int) && !$past(tc_wr) |-> flag_done);

    a_r4_hold_steady: assert property (@(posedge clk) disable iff (rst)
        count_hold_chg |-> ((age >= 2'd1) && $fell(gate_int)));

    a_r9_wake: assert property (@(posedge clk) disable iff (rst)
        (irq && wait_mode) |-> wake_req);

    a_r10_stop_hold: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(stop_mode) && !$past(tc_wr) |-> $stable(gate_int));

    a_r11_zero_code: assert property (@(posedge clk) disable iff (rst)
        (tc_wr && tc_data == 4'd0) |=> !gate_int);
endmodule

module gec_hold_watch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hold,
    output logic             chg
);
    logic [CNT_W-1:0] last;
    logic             valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            last  <= '0;
            valid <= 1'b0;
        end else begin
            last  <= hold;
            valid <= 1'b1;
        end
    end

    assign chg = valid & (hold != last);
endmodule

bind gated_event_counter gec_hold_watch #(.CNT_W(CNT_W)) u_hw (
    .clk (clk),
    .rst (rst),
    .hold(count_hold),
    .chg ()
);

bind gated_event_counter gec_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .tc_wr         (tc_wr),
    .tc_data       (tc_data),
    .stop_mode     (stop_mode),
    .wait_mode     (wait_mode),
    .irq           (irq),
    .wake_req      (wake_req),
    .gate_int      (gate_int),
    .gate_ext      (gate_ext),
    .flag_done     (flag_done),
    .flag_ovf      (flag_ovf),
    .count_hold_chg(u_hw.chg)
);

// File: tb/sim_gated_event_counter.sv
module sim_gated_event_counter;
    localparam int unsigned BASE = 40;
    localparam int          CW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tc_wr = 1'b0;
    logic [3:0]    tc_data = 4'd0;
    logic          en_done = 1'b0, en_ovf = 1'b0;
    logic          clr_done = 1'b0, clr_ovf = 1'b0;
    logic          event_in = 1'b0;
    logic          wait_mode = 1'b0, stop_mode = 1'b0;
    logic          gate_int, gate_ext, flag_done, flag_ovf, irq, wake_req;
    logic [CW-1:0] count_hold;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gated_event_counter #(.BASE_CYCLES(BASE), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .tc_wr(tc_wr), .tc_data(tc_data),
        .en_done(en_done), .en_ovf(en_ovf), .clr_done(clr_done), .clr_ovf(clr_ovf),
        .event_in(event_in), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .gate_int(gate_int), .gate_ext(gate_ext), .count_hold(count_hold),
        .flag_done(flag_done), .flag_ovf(flag_ovf), .irq(irq), .wake_req(wake_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_code(input logic [3:0] c);
        @(negedge clk);
        tc_wr = 1'b1;
        tc_data = c;
        @(negedge clk);
        tc_wr = 1'b0;
    endtask

    task automatic wait_rise();
        logic p;
        p = gate_int;
        forever begin
            @(negedge clk);
            if (gate_int && !p) break;
            p = gate_int;
        end
    endtask

    task automatic wait_fall();
        logic p;
        p = gate_int;
        forever begin
            @(negedge clk);
            if (!gate_int && p) break;
            p = gate_int;
        end
    endtask

    task automatic pulse_event();
        event_in = 1'b1;
        repeat (2) @(negedge clk);
        event_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R12 gate_int", gate_int, 0);
        check("R12 gate_ext", gate_ext, 0);
        check("R12 flags", {flag_done, flag_ovf}, 0);
        check("R12 irq/wake", {irq, wake_req}, 0);
        check("R12 hold", count_hold, 0);
    endtask

    task automatic t_timing();
        int n;
        write_code(4'd1);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            check("R1 gate low before 4th edge", gate_int, 0);
        end
        @(negedge clk);
        check("R1 gate high at 4th edge", gate_int, 1);
        @(negedge clk);
        check("R3 ext low after 1 cycle", gate_ext, 0);
        @(negedge clk);
        check("R3 ext high after 2 cycles", gate_ext, 1);
        n = 3;
        while (gate_int) begin @(negedge clk); if (gate_int) n++; end
        check("R2 first window length", n, 40);
        n = 1;
        @(negedge clk);
        while (!gate_int) begin n++; @(negedge clk); end
        check("R2 gap length", n, 40);
        n = 1;
        @(negedge clk);
        while (gate_int) begin n++; @(negedge clk); end
        check("R2 second window length", n, 40);
    endtask

    task automatic t_count_wait();
        en_done = 1'b1;
        en_ovf = 1'b0;
        wait_mode = 1'b1;
        write_code(4'd2);
        wait_rise();
        check("R8 flags zero at open", {flag_done, flag_ovf}, 0);
        repeat (5) pulse_event();
        wait_fall();
        check("R4 R9 hold counts 5 in wait", count_hold, 5);
        check("R5 done set at close", flag_done, 1);
        check("R5 irq with enable", irq, 1);
        check("R9 wake request", wake_req, 1);
        wait_mode = 1'b0;
        @(negedge clk);
        check("R9 no wake outside wait", wake_req, 0);
        wait_rise();
        check("R8 done cleared at next open", flag_done, 0);
        repeat (2) pulse_event();
        check("R4 hold stable mid-window", count_hold, 5);
        wait_fall();
        check("R4 hold updates at close", count_hold, 2);
    endtask

    task automatic t_overflow_w1c();
        en_done = 1'b0;
        en_ovf = 1'b1;
        write_code(4'd15);
        wait_rise();
        for (int i = 0; i < 257; i++) begin
            event_in = 1'b1;
            @(negedge clk);
            event_in = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R6 overflow flag", flag_ovf, 1);
        check("R6 overflow irq", irq, 1);
        wait_fall();
        check("R6 count wraps to 1", count_hold, 1);
        check("R5 done after overflow window", flag_done, 1);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        check("R7 ovf cleared", flag_ovf, 0);
        check("R7 done untouched", flag_done, 1);
        check("R7 irq drops", irq, 0);
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        check("R7 done cleared", flag_done, 0);
    endtask

    task automatic t_stop();
        en_ovf = 1'b0;
        write_code(4'd2);
        wait_rise();
        pulse_event();
        stop_mode = 1'b1;
        @(negedge clk);
        pulse_event();
        repeat (4) @(negedge clk);
        check("R10 gate held in stop", gate_int, 1);
        stop_mode = 1'b0;
        pulse_event();
        wait_fall();
        check("R10 event during stop ignored", count_hold, 2);
    endtask

    task automatic t_zero();
        int seen;
        write_code(4'd0);
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (gate_int) seen++;
        end
        check("R11 gate idle with zero code", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timing();
        t_count_wait();
        t_overflow_w1c();
        t_stop();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule